// File: doc/BRIEF.md
# Two-Wire Bus Stuck-Low Timeout Monitor

This block watches the clock and data lines of a two-wire serial bus and reports when either one has been held low for too long. The raw line levels pass through a two-flop synchronizer. A prescaler divides the system clock down to a slow timebase of roughly 1 kHz, and the block counts in ticks of that timebase, not in system clocks. The prescaler's tick is also brought out so that other bus ports can share the same timebase.

Each line has its own low-time counter. A counter advances on every tick while its line is low and goes back to zero as soon as the line is seen high. When a counter reaches the programmed limit, a sticky timeout flag is set. Software clears the flag by pulsing the clear input. If the expired line is the data line and the reset enable is set, the block also sends a one-cycle reset request to the host engine. A programmed limit of zero selects a built-in default of 25 ticks, which is about 25 ms at 1.024 kHz.

Top module: `bus_stuck_monitor`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `timeout_o` and `rst_req_o` are low.
- R2: `tick_o` is high for exactly one clock cycle in every TICK_DIV clock cycles.
- R3: When the clock line is held low, `timeout_o` rises within three clocks after the limit-th tick counted while the line is low, and it is still low three clocks after the tick before that.
- R4: The data line held low sets `timeout_o` after the same number of ticks as in R3.
- R5: A `limit_i` value of 0 selects the default limit of 25 ticks.
- R6: A line that is seen high, even briefly, restarts its count from zero, so a fresh full limit of low ticks is needed before expiry.
- R7: `timeout_o` stays set until `clear_i` is pulsed. A line that stays low after its expiry does not set the flag again until it has gone high and then low for a full limit.
- R8: `rst_req_o` is a single-cycle pulse that fires only when the data line expires while `dat_rst_en_i` is 1. A clock-line expiry, or a data-line expiry with the enable at 0, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw clock-line level |
| sda_i | input | 1 | Raw data-line level |
| limit_i | input | CNT_W | Timeout length in ticks; 0 selects the default |
| dat_rst_en_i | input | 1 | Allows a data-line expiry to request a host reset |
| clear_i | input | 1 | Clears the timeout flag (write-one-to-clear pulse) |
| tick_o | output | 1 | Timebase tick, one clock wide |
| timeout_o | output | 1 | Sticky timeout flag |
| rst_req_o | output | 1 | One-cycle host reset request |

## Verification
The hardest case to reach from the ports is a line that rises and falls again between two ticks, because the count must drop back to zero without any tick ever seeing the line high. To reach it, the bench lines up with an observed `tick_o` pulse. It then raises the data line for four clocks, which is long enough to pass the synchronizer but shorter than the tick interval. After that, the bench shows that a full new limit of ticks is needed before expiry. A second case, a line that is still stuck after the flag has been cleared, is reached by holding the line low across the clear pulse and counting further ticks.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int NUM_LINES = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;

  // A programmed value of zero falls back to the default limit.
  function automatic logic [7:0] pick_limit(input logic [7:0] prog, input logic [7:0] dflt);
    return (prog == 8'd0) ? dflt : prog;
  endfunction
endpackage

// File: rtl/bsm_sync.sv
module bsm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage_q[s] <= '1;   // idle bus reads high
        end else if (s == 0) begin
          stage_q[s] <= d_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bsm_prescaler.sv
module bsm_prescaler #(
  parameter int DIV = 48828
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bsm_low_timer.sv
module bsm_low_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (line_i) begin
        cnt_q <= '0;
      end else if (tick_i && (cnt_q < limit_i)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == limit_i - 1'b1) expire_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_stuck_monitor.sv
module bus_stuck_monitor
  import bsm_pkg::*;
#(
  parameter int TICK_DIV      = 48828,
  parameter int CNT_W         = 8,
  parameter int DEFAULT_LIMIT = 25,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             dat_rst_en_i,
  input  logic             clear_i,
  output logic             tick_o,
  output logic             timeout_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W-1:0] DFLT = CNT_W'(DEFAULT_LIMIT);

  logic [NUM_LINES-1:0] raw_lines, sync_lines, expire;
  logic [CNT_W-1:0]     eff_limit;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;
  assign eff_limit = (limit_i == '0) ? DFLT : limit_i;

  bsm_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_lines), .q_o(sync_lines));

  bsm_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst(rst), .tick_o(tick_o));

  genvar l;
  generate
    for (l = 0; l < NUM_LINES; l++) begin : g_line
      bsm_low_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .line_i(sync_lines[l]), .tick_i(tick_o),
        .limit_i(eff_limit), .expire_o(expire[l]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_o <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire[LINE_SDA] & dat_rst_en_i;
      if (|expire)      timeout_o <= 1'b1;
      else if (clear_i) timeout_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker (
  input logic clk,
  input logic rst,
  input logic clear_i,
  input logic dat_rst_en_i,
  input logic tick_o,
  input logic timeout_o,
  input logic rst_req_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!timeout_o && !rst_req_o));

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  assert_rise_after_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> $past(tick_o, 2));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(timeout_o) |-> $past(clear_i));

  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  assert_req_enabled_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(dat_rst_en_i));

  assert_req_with_flag_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> timeout_o);
endmodule

bind bus_stuck_monitor bsm_checker chk_i (
  .clk(clk), .rst(rst), .clear_i(clear_i), .dat_rst_en_i(dat_rst_en_i),
  .tick_o(tick_o), .timeout_o(timeout_o), .rst_req_o(rst_req_o));

// File: tb/bus_stuck_monitor_tb_top.sv
module bus_stuck_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int CW  = 8;

  logic clk = 0, rst = 1, scl = 1, sda = 1, en = 0, clr = 0;
  logic [CW-1:0] lim = 0;
  logic tick, tmo, req;
  int checks = 0, errors = 0, req_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_stuck_monitor #(.TICK_DIV(DIV), .CNT_W(CW), .DEFAULT_LIMIT(25)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .limit_i(lim),
    .dat_rst_en_i(en), .clear_i(clr), .tick_o(tick), .timeout_o(tmo),
    .rst_req_o(req));

  always @(negedge clk) if (!rst && req) req_cnt++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int k);
    for (int i = 0; i < k; i++) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic do_clear();
    clr = 1; @(negedge clk); clr = 0; @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 flag in reset", tmo, 0);
    check("R1 req in reset", req, 0);
    rst = 0; @(negedge clk);
    check("R1 flag after reset", tmo, 0);
  endtask

  task automatic t_tick();
    int gap = 0;
    wait_ticks(1);
    @(negedge clk);
    check("R2 tick width", tick, 0);
    gap = 1;
    while (!tick) begin @(negedge clk); gap++; end
    check("R2 tick period", gap, DIV);
  endtask

  task automatic t_scl();
    int r0 = req_cnt;
    lim = 3; en = 1;
    wait_ticks(1); scl = 0;
    wait_ticks(2); settle();
    check("R3 scl no flag at limit-1", tmo, 0);
    wait_ticks(1); settle();
    check("R3 scl flag at limit", tmo, 1);
    check("R8 no req for scl expiry", req_cnt - r0, 0);
    wait_ticks(2); settle();
    check("R7 flag held", tmo, 1);
    do_clear();
    check("R7 clear while stuck", tmo, 0);
    wait_ticks(4); settle();
    check("R7 no re-set while still stuck", tmo, 0);
    scl = 1; settle();
  endtask

  task automatic t_sda_req();
    int r0 = req_cnt;
    lim = 5; en = 1;
    wait_ticks(1); sda = 0;
    wait_ticks(4); settle();
    check("R4 sda no flag at limit-1", tmo, 0);
    wait_ticks(1); settle();
    check("R4 sda flag at limit", tmo, 1);
    check("R8 one req pulse", req_cnt - r0, 1);
    sda = 1; settle(); do_clear();
    check("R7 clear after release", tmo, 0);
  endtask

  task automatic t_restart();
    int r0 = req_cnt;
    lim = 4; en = 0;
    wait_ticks(1); sda = 0;
    wait_ticks(3);
    sda = 1; repeat (4) @(negedge clk); sda = 0;
    wait_ticks(3); settle();
    check("R6 count restarted", tmo, 0);
    wait_ticks(1); settle();
    check("R6 flag after full limit", tmo, 1);
    check("R8 no req with enable low", req_cnt - r0, 0);
    sda = 1; settle(); do_clear();
  endtask

  task automatic t_default();
    lim = 0;
    wait_ticks(1); scl = 0;
    wait_ticks(24); settle();
    check("R5 default no flag at 24", tmo, 0);
    wait_ticks(1); settle();
    check("R5 default flag at 25", tmo, 1);
    scl = 1; settle(); do_clear();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_tick();
    t_scl();
    t_sda_req();
    t_restart();
    t_default();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule